// File: doc/BRIEF.md
# Paired-Set Balancing Tag Cache

This block is a set-associative tag array that evens out pressure across its sets. Every set has one fixed partner: the set whose index differs only in the most significant index bit. A small saturating counter per set tracks how hard the set is missing. When a heavily missed set has to drop a line and its partner is lightly used, the victim is moved into the partner and kept there with a displaced flag. The victim is not lost.

A lookup carries an address. The low index bits select the set and the upper bits are the tag. The block answers with one of three outcomes: first hit, secondary hit (found among the lines displaced into the partner) or miss. On a miss the requested tag is filled at once. Whenever a valid line leaves the cache, the full address of that line is reported. Lookups are handled one at a time. A lookup that needs the partner probe takes one extra cycle. The block holds tags only. Data, refill and write-back belong to the surrounding cache.

Top module: `pair_balance_cache`

## Requirements
- R1: A synchronous active-high `rst` empties every line, zeroes all counters and clears all second-search flags. After reset `req_ready` is 1 and `resp_valid` and `evict_valid` are 0. The first lookup of any address then misses and reports no eviction.
- R2: The address is split as {tag, index}, with the index in the low log2(SETS) bits. The first probe hits only on a valid line in the indexed set whose tag matches and whose displaced flag is 0. Such a hit is reported as `resp_kind` = 2'b01. A displaced line never matches the first probe.
- R3: A lookup is accepted on a rising edge with `req_valid` and `req_ready` high, and `req_ready` then stays low until the response. `resp_valid` is a one-cycle pulse. It rises on the second rising edge after acceptance when the first probe decides the result. It rises on the third edge when a second probe is needed.
- R4: A second probe runs only when the first probe misses and the indexed set's second-search flag is set. That probe looks in the partner set (index with its MSB inverted) for a valid line with a matching tag and displaced flag 1. A match is reported as `resp_kind` = 2'b10 and makes that line MRU in the partner.
- R5: A miss is reported as `resp_kind` = 2'b00. The requested tag is installed as a native line in the indexed set and made MRU. It takes the lowest-numbered invalid way, or the LRU way when the set is full.
- R6: Each set's counter ranges over 0 to 2K-1, with K the number of ways. A miss in the set adds 1 and a first or secondary hit subtracts 1. The counter saturates at both ends without wrapping. Only the indexed set's counter changes.
- R7: On a miss, the victim moves into the partner when three conditions hold, all judged on counter values from before the lookup: the victim is valid and native, the indexed set's counter is 2K-1, and the partner's counter is below K. The moved line becomes a displaced MRU line of the partner, taking its lowest invalid way or else its LRU way. The indexed set's second-search flag is then set.
- R8: `evict_valid` pulses together with a miss response exactly when a valid line leaves the cache. This is the partner's replaced line after a move, or otherwise the indexed set's victim. `evict_addr` gives that line's tag with the index of the set it was first filled into.
- R9: A first hit makes the hit line MRU of its set, so a later miss in that set replaces another way.
- R10: With `PRECISE_CLEAR` = 1, a set's second-search flag clears once no valid displaced line from it remains in the partner. Later misses to that set then respond on the second edge. With `PRECISE_CLEAR` = 0 the flag stays set until reset.
- R11: A displaced line chosen as victim in the set that holds it is never moved again. It leaves the cache directly and is reported under its home index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | TAG_W+log2(SETS) | Lookup address {tag, index} |
| req_ready | output | 1 | Block idle and able to accept a lookup |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_kind | output | 2 | 00 miss, 01 first hit, 10 secondary hit |
| evict_valid | output | 1 | A valid line left the cache with this result |
| evict_addr | output | TAG_W+log2(SETS) | Home address {tag, index} of the departed line |

## Verification
The hardest situation to reach is a move. It needs a set driven to its top counter value by consecutive misses while the partner stays below half of that range. After that, the displaced line has to be chased into a secondary hit and finally pushed out of the partner so that the flag clears. Directed sequences build each of these states from reset with chosen tag orders, including a partner that is too busy to accept a move. A long pseudo-random sweep then concentrates most lookups on two set pairs with a tag pool larger than the ways, so that saturation, moves, displaced victims and flag clearing keep recurring. The bench predicts every response, latency and evicted address with its own timestamp-based model.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
   typedef enum logic [1:0] {
      KIND_MISS = 2'b00,
      KIND_HIT  = 2'b01,
      KIND_SEC  = 2'b10
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PROBE1 = 2'd1,
      ST_PROBE2 = 2'd2
   } state_e;
endpackage

// File: rtl/pbc_satcnt.sv
// Per-set pressure counter: saturating up/down.
module pbc_satcnt #(
   parameter int MAXV = 3,
   localparam int CW = $clog2(MAXV + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] TOPV = CW'(MAXV);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (inc && cnt != TOPV)
         cnt <= cnt + CW'(1);
      else if (dec && cnt != '0)
         cnt <= cnt - CW'(1);
   end
endmodule

// File: rtl/pbc_probe.sv
// Combinational probe of one set: tag match with a chosen displaced flag,
// plus replacement choice (lowest invalid way, else the oldest way).
module pbc_probe #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 5,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0]            dsp,
   input  logic [WAYS-1:0][WAY_W-1:0] ages,
   input  logic [TAG_W-1:0]           cmp_tag,
   input  logic                       want_dsp,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way,
   output logic [WAY_W-1:0]           vic_way,
   output logic                       vic_vld,
   output logic [TAG_W-1:0]           vic_tag,
   output logic                       vic_dsp
);
   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   logic found_inv;

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!hit && vld[w] && (dsp[w] == want_dsp) && (tags[w] == cmp_tag)) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end

      found_inv = 1'b0;
      vic_way   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found_inv && !vld[w]) begin
            found_inv = 1'b1;
            vic_way   = WAY_W'(w);
         end
      end
      if (!found_inv) begin
         for (int w = 0; w < WAYS; w++) begin
            if (ages[w] == OLDEST)
               vic_way = WAY_W'(w);
         end
      end

      vic_vld = vld[vic_way];
      vic_tag = tags[vic_way];
      vic_dsp = dsp[vic_way];
   end
endmodule

// File: rtl/pair_balance_cache.sv
module pair_balance_cache
   import pbc_pkg::*;
#(
   parameter int WAYS          = 2,
   parameter int SETS          = 4,
   parameter int TAG_W         = 5,
   parameter bit PRECISE_CLEAR = 1'b1,
   localparam int IDX_W  = $clog2(SETS),
   localparam int ADDR_W = TAG_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [1:0]        resp_kind,
   output logic              evict_valid,
   output logic [ADDR_W-1:0] evict_addr
);
   localparam int WAY_W = $clog2(WAYS);
   localparam int CNT_W = $clog2(2 * WAYS);
   localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(2 * WAYS - 1);
   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(WAYS);
   localparam logic [IDX_W-1:0] FLIP      = IDX_W'(1) << (IDX_W - 1);

   // elaboration-time parameter checks
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be at least 1");
   end

   typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

   function automatic ages_t make_mru(input ages_t a, input logic [WAY_W-1:0] w);
      ages_t r;
      for (int i = 0; i < WAYS; i++)
         r[i] = (a[i] < a[w]) ? a[i] + WAY_W'(1) : a[i];
      r[w] = '0;
      return r;
   endfunction

   state_e                               state_q;
   logic [ADDR_W-1:0]                    addr_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
   logic [SETS-1:0][WAYS-1:0]            vld_q;
   logic [SETS-1:0][WAYS-1:0]            dsp_q;
   ages_t [SETS-1:0]                     age_q;
   logic [SETS-1:0]                      sc_q;
   logic [SETS-1:0][CNT_W-1:0]           cnt;

   logic [IDX_W-1:0] s_idx, p_idx;
   logic [TAG_W-1:0] s_tag;

   assign s_idx = addr_q[IDX_W-1:0];
   assign s_tag = addr_q[ADDR_W-1:IDX_W];
   assign p_idx = s_idx ^ FLIP;

   // first probe: indexed set, native lines
   logic             own_hit, own_vic_vld, own_vic_dsp;
   logic [WAY_W-1:0] own_hit_way, own_vic_way;
   logic [TAG_W-1:0] own_vic_tag;

   pbc_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_own (
      .tags(tag_q[s_idx]), .vld(vld_q[s_idx]), .dsp(dsp_q[s_idx]),
      .ages(age_q[s_idx]), .cmp_tag(s_tag), .want_dsp(1'b0),
      .hit(own_hit), .hit_way(own_hit_way), .vic_way(own_vic_way),
      .vic_vld(own_vic_vld), .vic_tag(own_vic_tag), .vic_dsp(own_vic_dsp)
   );

   // second probe: partner set, displaced lines
   logic             mate_hit, mate_vic_vld, mate_vic_dsp;
   logic [WAY_W-1:0] mate_hit_way, mate_vic_way;
   logic [TAG_W-1:0] mate_vic_tag;

   pbc_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_mate (
      .tags(tag_q[p_idx]), .vld(vld_q[p_idx]), .dsp(dsp_q[p_idx]),
      .ages(age_q[p_idx]), .cmp_tag(s_tag), .want_dsp(1'b1),
      .hit(mate_hit), .hit_way(mate_hit_way), .vic_way(mate_vic_way),
      .vic_vld(mate_vic_vld), .vic_tag(mate_vic_tag), .vic_dsp(mate_vic_dsp)
   );

   logic in_p1, in_p2, need_p2, commit, first_hit, sec_hit, miss, do_move;
   logic own_dsp_others, sc_drop;

   assign in_p1     = (state_q == ST_PROBE1);
   assign in_p2     = (state_q == ST_PROBE2);
   assign need_p2   = in_p1 && !own_hit && sc_q[s_idx];
   assign commit    = (in_p1 && !need_p2) || in_p2;
   assign first_hit = in_p1 && own_hit;
   assign sec_hit   = in_p2 && mate_hit;
   assign miss      = commit && !first_hit && !sec_hit;
   assign do_move   = miss && own_vic_vld && !own_vic_dsp &&
                      (cnt[s_idx] == CNT_TOP) && (cnt[p_idx] < CNT_LIMIT);

   assign own_dsp_others =
      |(vld_q[s_idx] & dsp_q[s_idx] & ~(WAYS'(1) << own_vic_way));

   // flag clearing variant
   if (PRECISE_CLEAR) begin : g_precise
      assign sc_drop = miss && own_vic_vld && own_vic_dsp && !own_dsp_others;
   end else begin : g_sticky
      assign sc_drop = 1'b0;
   end

   // one pressure counter per set
   for (genvar g = 0; g < SETS; g++) begin : g_cnt
      pbc_satcnt #(.MAXV(2 * WAYS - 1)) u_cnt (
         .clk(clk), .rst(rst),
         .inc(miss && (s_idx == IDX_W'(g))),
         .dec((first_hit || sec_hit) && (s_idx == IDX_W'(g))),
         .cnt(cnt[g])
      );
   end

   assign req_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         tag_q       <= '0;
         vld_q       <= '0;
         dsp_q       <= '0;
         sc_q        <= '0;
         resp_valid  <= 1'b0;
         resp_kind   <= KIND_MISS;
         evict_valid <= 1'b0;
         evict_addr  <= '0;
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else begin
         resp_valid  <= commit;
         resp_kind   <= first_hit ? KIND_HIT : (sec_hit ? KIND_SEC : KIND_MISS);
         evict_valid <= miss && (do_move ? mate_vic_vld : own_vic_vld);
         evict_addr  <= do_move ? {mate_vic_tag, (mate_vic_dsp ? s_idx : p_idx)}
                                : {own_vic_tag,  (own_vic_dsp  ? p_idx : s_idx)};

         case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               state_q <= ST_PROBE1;
            end
            ST_PROBE1: state_q <= need_p2 ? ST_PROBE2 : ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase

         if (first_hit)
            age_q[s_idx] <= make_mru(age_q[s_idx], own_hit_way);
         if (sec_hit)
            age_q[p_idx] <= make_mru(age_q[p_idx], mate_hit_way);
         if (miss) begin
            tag_q[s_idx][own_vic_way] <= s_tag;
            vld_q[s_idx][own_vic_way] <= 1'b1;
            dsp_q[s_idx][own_vic_way] <= 1'b0;
            age_q[s_idx]              <= make_mru(age_q[s_idx], own_vic_way);
         end
         if (do_move) begin
            tag_q[p_idx][mate_vic_way] <= own_vic_tag;
            vld_q[p_idx][mate_vic_way] <= 1'b1;
            dsp_q[p_idx][mate_vic_way] <= 1'b1;
            age_q[p_idx]               <= make_mru(age_q[p_idx], mate_vic_way);
            sc_q[s_idx]                <= 1'b1;
         end
         if (sc_drop)
            sc_q[p_idx] <= 1'b0;
      end
   end
endmodule

// File: rtl/pair_balance_cache_chk.sv
module pair_balance_cache_chk (
   input logic       clk,
   input logic       rst,
   input logic       req_valid,
   input logic       req_ready,
   input logic       resp_valid,
   input logic [1:0] resp_kind,
   input logic       evict_valid
);
   p_kind_legal_r2: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> (resp_kind != 2'b11));

   p_resp_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      resp_valid |=> !resp_valid);

   p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

   p_idle_on_resp_r3: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> req_ready);

   p_sec_two_probes_r4: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && resp_kind == 2'b10) |-> (!$past(req_ready) && !$past(req_ready, 2)));

   p_evict_only_miss_r8: assert property (@(posedge clk) disable iff (rst)
      evict_valid |-> (resp_valid && resp_kind == 2'b00));
endmodule

bind pair_balance_cache pair_balance_cache_chk u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .resp_valid(resp_valid), .resp_kind(resp_kind), .evict_valid(evict_valid)
);

// File: tb/pair_balance_cache_test.sv
module pair_balance_cache_test;
   localparam int WAYS   = 2;
   localparam int SETS   = 4;
   localparam int TAG_W  = 5;
   localparam int IDX_W  = 2;
   localparam int ADDR_W = TAG_W + IDX_W;
   localparam int TOPC   = 2 * WAYS - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_ready, resp_valid, evict_valid;
   logic [1:0]        resp_kind;
   logic [ADDR_W-1:0] evict_addr;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   pair_balance_cache #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_kind(resp_kind),
      .evict_valid(evict_valid), .evict_addr(evict_addr)
   );

   // reference model: timestamps for recency
   int m_tag   [SETS][WAYS];
   bit m_v     [SETS][WAYS];
   bit m_d     [SETS][WAYS];
   int m_stamp [SETS][WAYS];
   int m_cnt   [SETS];
   int now;

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < SETS; s++) begin
         m_cnt[s] = 0;
         for (int w = 0; w < WAYS; w++) begin
            m_v[s][w] = 0; m_d[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
         end
      end
      now = 0;
   endtask

   function automatic int pick(input int s);
      int best = -1;
      for (int w = 0; w < WAYS; w++)
         if (best < 0 && !m_v[s][w]) best = w;
      if (best >= 0) return best;
      best = 0;
      for (int w = 1; w < WAYS; w++)
         if (m_stamp[s][w] < m_stamp[s][best]) best = w;
      return best;
   endfunction

   task automatic model_access(input int addr, output int kind, output int ev,
                               output int evaddr, output int lat);
      int s, t, p, vw, pw;
      bit sc, vv, vd;
      int vt;
      s = addr % SETS; t = addr / SETS; p = s ^ (SETS / 2);
      now++;
      kind = 0; ev = 0; evaddr = 0; lat = 2;
      for (int w = 0; w < WAYS; w++)
         if (kind == 0 && m_v[s][w] && !m_d[s][w] && m_tag[s][w] == t) begin
            kind = 1; m_stamp[s][w] = now;
         end
      if (kind == 1) begin
         if (m_cnt[s] > 0) m_cnt[s]--;
         return;
      end
      sc = 0;
      for (int w = 0; w < WAYS; w++) if (m_v[p][w] && m_d[p][w]) sc = 1;
      if (sc) begin
         lat = 3;
         for (int w = 0; w < WAYS; w++)
            if (kind == 0 && m_v[p][w] && m_d[p][w] && m_tag[p][w] == t) begin
               kind = 2; m_stamp[p][w] = now;
            end
         if (kind == 2) begin
            if (m_cnt[s] > 0) m_cnt[s]--;
            return;
         end
      end
      vw = pick(s); vv = m_v[s][vw]; vd = m_d[s][vw]; vt = m_tag[s][vw];
      if (vv && !vd && m_cnt[s] == TOPC && m_cnt[p] < WAYS) begin
         pw = pick(p);
         if (m_v[p][pw]) begin
            ev = 1; evaddr = m_tag[p][pw] * SETS + (m_d[p][pw] ? s : p);
         end
         m_tag[p][pw] = vt; m_v[p][pw] = 1; m_d[p][pw] = 1; m_stamp[p][pw] = now;
      end else if (vv) begin
         ev = 1; evaddr = vt * SETS + (vd ? p : s);
      end
      m_tag[s][vw] = t; m_v[s][vw] = 1; m_d[s][vw] = 0; m_stamp[s][vw] = now;
      if (m_cnt[s] < TOPC) m_cnt[s]++;
   endtask

   // one lookup, compared with the model; called at a falling edge
   task automatic access(input int addr, input string req);
      int ek, eev, eaddr, elat, lat;
      model_access(addr, ek, eev, eaddr, elat);
      check("R3", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_addr  = ADDR_W'(addr);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!resp_valid && lat < 10) begin
         @(negedge clk);
         lat++;
      end
      check(req, $sformatf("kind addr=%0d", addr), int'(resp_kind), ek);
      check("R3", $sformatf("latency addr=%0d", addr), lat, elat);
      check("R8", $sformatf("evict_valid addr=%0d", addr), int'(evict_valid), eev);
      if (eev) check("R8", "evict_addr", int'(evict_addr), eaddr);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      int r, set, tg;
      model_reset();
      do_reset();
      // R1: reset state
      check("R1", "req_ready after reset", int'(req_ready), 1);
      check("R1", "resp_valid after reset", int'(resp_valid), 0);
      check("R1", "evict_valid after reset", int'(evict_valid), 0);
      access(0, "R1");
      access(0, "R2");
      // R9: set 1, hit keeps tag1, tag2 leaves
      access(1 * SETS + 1, "R5");
      access(2 * SETS + 1, "R5");
      access(1 * SETS + 1, "R9");
      access(3 * SETS + 1, "R9");

      // R7, R4, R2, R11, R10 on set 0 / partner set 2
      do_reset();
      for (int t = 1; t <= 3; t++) access(t * SETS, "R5");
      access(4 * SETS, "R7");
      access(2 * SETS, "R4");
      access(2 * SETS + 2, "R2");
      access(5 * SETS + 2, "R11");
      access(2 * SETS, "R10");

      // R7: partner too busy, victim leaves directly
      do_reset();
      access(1 * SETS + 3, "R5");
      access(2 * SETS + 3, "R5");
      for (int t = 1; t <= 4; t++) access(t * SETS + 1, "R7");
      access(2 * SETS + 1, "R7");

      // R6: counter floors at zero, then climbs to the top
      do_reset();
      access(1 * SETS, "R5");
      for (int i = 0; i < 5; i++) access(1 * SETS, "R6");
      for (int t = 2; t <= 5; t++) access(t * SETS, "R6");
      access(4 * SETS, "R6");

      // skewed pseudo-random sweep
      do_reset();
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         r = int'(lf);
         set = ((r >> 2) % 8 < 6) ? (((r >> 5) & 1) ? 2 : 0) + (r & 1) * 0 + ((r >> 6) & 1) : (r & 3);
         tg = (r >> 8) % 6;
         access(tg * SETS + set, "R5");
      end
      finish_run();
   end
endmodule